// File: doc/BRIEF.md
# Profile Pin Multi-Level Modulator

This block drives one synthesis channel. It keeps a bank of sixteen 32-bit profile words. Slot 0 of the bank is the base frequency tuning word. A separate base phase offset and a separate base amplitude word sit beside the bank. External profile pins form a level index. The index picks one profile word, and that word replaces the frequency, the phase or the amplitude, depending on the configured modulation kind. Modulation can use 2, 4, 8 or 16 levels. The kind can also be "none", which gives a single tone from the base values.

All writes land in shadow copies. An I/O-update strobe copies every shadow register into its active register in one cycle, so several channels or several fields can be retuned together. The active frequency word feeds a 32-bit phase accumulator. The accumulator can be held at zero, or cleared once at an update. Its top bits plus the phase offset form the registered output phase.

Top module: `profile_modulator`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ftw_o`, `pow_o`, `amp_o` and `phase_o` are all zero.
- R2: A write changes nothing at the outputs until `io_update` is pulsed. The edge on which `io_update` is high copies every shadow register to its active register. The outputs reflect the new active values one clock edge later.
- R3: Write addresses select the target register:
  - address 0 is the control word: bits [1:0] are the kind (0 none, 1 frequency, 2 phase, 3 amplitude); bits [3:2] are the depth code; bit 4 is clear-and-hold; bit 5 is auto-clear.
  - address 1 is the base phase, held in data bits [13:0].
  - address 2 is the base amplitude, held in data bits [9:0].
  - address 16+k writes profile slot k, for k from 0 to 15.
- R4: For depth code c, pins P0..Pc form the level index, with P0 as its most significant bit. In 16-level mode P1 and P3 high select profile 5. Pins above Pc are ignored.
- R5: In frequency mode `ftw_o` equals profile slot [index], where slot 0 is the base tuning word. `pow_o` and `amp_o` keep their base values.
- R6: In phase mode `pow_o` equals bits [31:18] of profile slot [index] for a nonzero index, and the base phase for index 0. `ftw_o` is slot 0.
- R7: In amplitude mode `amp_o` equals bits [31:22] of profile slot [index] for a nonzero index, and the base amplitude for index 0.
- R8: With kind none the pins have no effect. The outputs are slot 0, the base phase and the base amplitude.
- R9: A change on the pins shows at the outputs after exactly two rising clock edges.
- R10: The accumulator adds the active `ftw_o` every cycle. The value `phase_o` is the top 14 accumulator bits plus `pow_o`, modulo 2^14, registered one cycle later.
- R11: While clear-and-hold is active, the accumulator stays at zero, so `phase_o` equals `pow_o`. After the bit is cleared, accumulation restarts from zero.
- R12: With auto-clear active, the accumulator is zeroed once, one cycle after each update edge, and then accumulates again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_addr | input | 5 | Shadow register address |
| cfg_wdata | input | 32 | Write data |
| io_update | input | 1 | Copy shadow registers to active registers |
| prof_pins | input | 4 | Profile pins, bit i is pin Pi |
| ftw_o | output | 32 | Active frequency tuning word |
| pow_o | output | 14 | Active phase offset |
| amp_o | output | 10 | Active amplitude word |
| phase_o | output | 14 | Accumulated phase plus offset |

## Verification
The embedded assertions check several rules on every cycle:
- active state stays untouched by anything except an update strobe;
- the level index never exceeds the range the depth allows;
- single-tone outputs follow the base registers;
- the accumulator reads zero after a clear-and-hold cycle or after an auto-clear cycle.

Only the bench scenarios can show the rest:
- the pin-to-index mapping and the bit alignment of phase and amplitude words for each depth and kind;
- the two-edge pin latency;
- the exact accumulation arithmetic after a clear is released.

// File: rtl/profmod_pkg.sv
package profmod_pkg;
  typedef enum logic [1:0] {
    MOD_NONE  = 2'd0,
    MOD_FREQ  = 2'd1,
    MOD_PHASE = 2'd2,
    MOD_AMP   = 2'd3
  } mod_kind_e;

  // packed MSB first: auto_clr is bit 5, kind is bits [1:0]
  typedef struct packed {
    logic      auto_clr;
    logic      clr_hold;
    logic [1:0] depth;
    mod_kind_e kind;
  } mod_ctrl_t;

  localparam int CTRL_W = 6;
endpackage

// File: rtl/prof_shadow_bank.sv
module prof_shadow_bank
  import profmod_pkg::*;
#(
  parameter int NPROF = 16,
  parameter int FTW_W = 32,
  parameter int POW_W = 14,
  parameter int AMP_W = 10,
  localparam int IDX_W = $clog2(NPROF),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [FTW_W-1:0]                wr_data,
  input  logic                            io_update,
  output mod_ctrl_t                       act_ctrl,
  output logic [NPROF-1:0][FTW_W-1:0]     act_bank,
  output logic [POW_W-1:0]                act_pow,
  output logic [AMP_W-1:0]                act_amp
);
  mod_ctrl_t                   sh_ctrl;
  logic [NPROF-1:0][FTW_W-1:0] sh_bank;
  logic [POW_W-1:0]            sh_pow;
  logic [AMP_W-1:0]            sh_amp;

  logic              to_bank;
  logic [IDX_W-1:0]  slot;
  assign to_bank = wr_addr[ADDR_W-1];
  assign slot    = wr_addr[IDX_W-1:0];

  // shadow side: written by the configuration port only
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ctrl <= '0;
      sh_bank <= '0;
      sh_pow  <= '0;
      sh_amp  <= '0;
    end else if (wr_en) begin
      if (to_bank) begin
        sh_bank[slot] <= wr_data;
      end else begin
        case (slot)
          IDX_W'(0): sh_ctrl <= mod_ctrl_t'(wr_data[CTRL_W-1:0]);
          IDX_W'(1): sh_pow  <= wr_data[POW_W-1:0];
          IDX_W'(2): sh_amp  <= wr_data[AMP_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // active side: whole-bank transfer on the update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ctrl <= '0;
      act_bank <= '0;
      act_pow  <= '0;
      act_amp  <= '0;
    end else if (io_update) begin
      act_ctrl <= sh_ctrl;
      act_bank <= sh_bank;
      act_pow  <= sh_pow;
      act_amp  <= sh_amp;
    end
  end

  // R2: active registers move only on an update edge
  p_hold_without_update_r2: assert property (@(posedge clk) disable iff (rst)
    !io_update |=> ($stable(act_ctrl) && $stable(act_bank) &&
                    $stable(act_pow) && $stable(act_amp)));
endmodule

// File: rtl/prof_level_select.sv
module prof_level_select
  import profmod_pkg::*;
#(
  parameter int NPROF = 16,
  parameter int FTW_W = 32,
  parameter int POW_W = 14,
  parameter int AMP_W = 10,
  localparam int IDX_W = $clog2(NPROF)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            pins,
  input  mod_ctrl_t                   act_ctrl,
  input  logic [NPROF-1:0][FTW_W-1:0] act_bank,
  input  logic [POW_W-1:0]            act_pow,
  input  logic [AMP_W-1:0]            act_amp,
  output logic [FTW_W-1:0]            ftw_o,
  output logic [POW_W-1:0]            pow_o,
  output logic [AMP_W-1:0]            amp_o
);
  logic [IDX_W-1:0] pin_q;
  logic [IDX_W-1:0] lvl_idx;
  logic [IDX_W-1:0] sel_idx;
  logic [FTW_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pins;
  end

  // lowest-numbered pin enters first and ends up most significant
  always_comb begin
    lvl_idx = '0;
    for (int i = 0; i < IDX_W; i++) begin
      if (i <= int'(act_ctrl.depth)) lvl_idx = {lvl_idx[IDX_W-2:0], pin_q[i]};
    end
  end

  assign sel_idx = (act_ctrl.kind == MOD_NONE) ? '0 : lvl_idx;
  assign word    = act_bank[sel_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_o <= '0;
      pow_o <= '0;
      amp_o <= '0;
    end else begin
      ftw_o <= (act_ctrl.kind == MOD_FREQ) ? word : act_bank[0];
      pow_o <= (act_ctrl.kind == MOD_PHASE && sel_idx != '0) ?
               word[FTW_W-1 -: POW_W] : act_pow;
      amp_o <= (act_ctrl.kind == MOD_AMP && sel_idx != '0) ?
               word[FTW_W-1 -: AMP_W] : act_amp;
    end
  end

  // R4: index never reaches beyond the levels the depth allows
  p_index_range_r4: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, lvl_idx} >> (int'(act_ctrl.depth) + 1)) == '0));

  // R8: single tone follows the base registers
  p_single_tone_r8: assert property (@(posedge clk) disable iff (rst)
    (act_ctrl.kind == MOD_NONE) |=>
      (ftw_o == $past(act_bank[0]) && pow_o == $past(act_pow) &&
       amp_o == $past(act_amp)));
endmodule

// File: rtl/prof_phase_acc.sv
module prof_phase_acc #(
  parameter int FTW_W = 32,
  parameter int POW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FTW_W-1:0] ftw,
  input  logic [POW_W-1:0] pow,
  input  logic             clr_hold,
  input  logic             auto_clr,
  input  logic             io_update,
  output logic [POW_W-1:0] phase_o
);
  logic [FTW_W-1:0] acc;
  logic             upd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      upd_d   <= 1'b0;
      phase_o <= '0;
    end else begin
      upd_d <= io_update;
      if (clr_hold || (auto_clr && upd_d)) acc <= '0;
      else                                 acc <= acc + ftw;
      phase_o <= acc[FTW_W-1 -: POW_W] + pow;
    end
  end

  // R11: held at zero while clear-and-hold is active
  p_clear_hold_r11: assert property (@(posedge clk) disable iff (rst)
    clr_hold |=> (acc == '0));

  // R12: one zeroing cycle following each update edge
  p_auto_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (auto_clr && upd_d) |=> (acc == '0));
endmodule

// File: rtl/profile_modulator.sv
module profile_modulator
  import profmod_pkg::*;
#(
  parameter int NPROF = 16,
  parameter int FTW_W = 32,
  parameter int POW_W = 14,
  parameter int AMP_W = 10,
  localparam int IDX_W = $clog2(NPROF),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [FTW_W-1:0]  cfg_wdata,
  input  logic              io_update,
  input  logic [IDX_W-1:0]  prof_pins,
  output logic [FTW_W-1:0]  ftw_o,
  output logic [POW_W-1:0]  pow_o,
  output logic [AMP_W-1:0]  amp_o,
  output logic [POW_W-1:0]  phase_o
);
  mod_ctrl_t                   act_ctrl;
  logic [NPROF-1:0][FTW_W-1:0] act_bank;
  logic [POW_W-1:0]            act_pow;
  logic [AMP_W-1:0]            act_amp;

  prof_shadow_bank #(.NPROF(NPROF), .FTW_W(FTW_W), .POW_W(POW_W), .AMP_W(AMP_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .io_update(io_update), .act_ctrl(act_ctrl), .act_bank(act_bank),
    .act_pow(act_pow), .act_amp(act_amp)
  );

  prof_level_select #(.NPROF(NPROF), .FTW_W(FTW_W), .POW_W(POW_W), .AMP_W(AMP_W)) u_sel (
    .clk(clk), .rst(rst), .pins(prof_pins), .act_ctrl(act_ctrl), .act_bank(act_bank),
    .act_pow(act_pow), .act_amp(act_amp), .ftw_o(ftw_o), .pow_o(pow_o), .amp_o(amp_o)
  );

  prof_phase_acc #(.FTW_W(FTW_W), .POW_W(POW_W)) u_acc (
    .clk(clk), .rst(rst), .ftw(ftw_o), .pow(pow_o), .clr_hold(act_ctrl.clr_hold),
    .auto_clr(act_ctrl.auto_clr), .io_update(io_update), .phase_o(phase_o)
  );
endmodule

// File: tb/profile_modulator_test.sv
module profile_modulator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        io_update = 1'b0;
  logic [3:0]  prof_pins = '0;
  logic [31:0] ftw_o;
  logic [13:0] pow_o;
  logic [9:0]  amp_o;
  logic [13:0] phase_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [31:0] BASE_F = 32'h000C_0000; // top 14 bits step by 3
  localparam logic [13:0] BASE_P = 14'd100;
  localparam logic [9:0]  BASE_A = 10'h155;

  profile_modulator uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .io_update(io_update), .prof_pins(prof_pins), .ftw_o(ftw_o), .pow_o(pow_o),
    .amp_o(amp_o), .phase_o(phase_o)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] pw(input int k);
    if (k == 0) return BASE_F;
    return (32'(k) << 28) | (32'(k) << 18) | 32'(k * 7);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk);
    io_update = 1'b1;
    @(negedge clk);
    io_update = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ftw", ftw_o, 0);
    chk("R1 pow", 32'(pow_o), 0);
    chk("R1 amp", 32'(amp_o), 0);
    chk("R1 phase", 32'(phase_o), 0);

    // load shadow registers (R3 address map)
    wr(5'd16, BASE_F);
    wr(5'd1, 32'(BASE_P));
    wr(5'd2, 32'(BASE_A));
    for (int k = 1; k < 16; k++) wr(5'(16 + k), pw(k));
    wr(5'd0, 32'h0000_000D); // kind freq, depth 3
    prof_pins = 4'b0001;     // would select slot 8 once active
    repeat (3) @(negedge clk);
    chk("R2 no effect before update", ftw_o, 0);
    chk("R2 pow before update", 32'(pow_o), 0);
    upd();
    @(negedge clk);
    chk("R2 after update", ftw_o, pw(8));

    // R4..R8 exhaustive sweep of kind, depth and pin pattern
    for (int kind = 0; kind < 4; kind++) begin
      for (int d = 0; d < 4; d++) begin
        wr(5'd0, 32'(kind | (d << 2)));
        upd();
        for (int p = 0; p < 16; p++) begin
          int idx;
          logic [31:0] ef;
          logic [13:0] ep;
          logic [9:0]  ea;
          @(negedge clk);
          prof_pins = 4'(p);
          @(negedge clk);
          @(negedge clk);
          idx = 0;
          for (int i = 0; i <= d; i++) idx = idx * 2 + ((p >> i) & 1);
          if (kind == 0) idx = 0;
          ef = (kind == 1) ? pw(idx) : BASE_F;
          ep = (kind == 2 && idx != 0) ? pw(idx)[31:18] : BASE_P;
          ea = (kind == 3 && idx != 0) ? pw(idx)[31:22] : BASE_A;
          case (kind)
            0: begin
              chk("R8 ftw", ftw_o, ef);
              chk("R8 pow", 32'(pow_o), 32'(ep));
              chk("R8 amp", 32'(amp_o), 32'(ea));
            end
            1: begin
              chk("R4/R5 ftw", ftw_o, ef);
              chk("R5 pow", 32'(pow_o), 32'(ep));
              chk("R5 amp", 32'(amp_o), 32'(ea));
            end
            2: begin
              chk("R6 ftw", ftw_o, ef);
              chk("R4/R6 pow", 32'(pow_o), 32'(ep));
              chk("R6 amp", 32'(amp_o), 32'(ea));
            end
            default: begin
              chk("R7 ftw", ftw_o, ef);
              chk("R7 pow", 32'(pow_o), 32'(ep));
              chk("R4/R7 amp", 32'(amp_o), 32'(ea));
            end
          endcase
        end
      end
    end

    // R4 named example: 16 levels, P1 and P3 high -> slot 5
    wr(5'd0, 32'h0000_000D);
    upd();
    @(negedge clk); prof_pins = 4'b1010;
    @(negedge clk); @(negedge clk);
    chk("R4 P1+P3 selects 5", ftw_o, pw(5));

    // R9 pin latency: two edges
    @(negedge clk); prof_pins = 4'b0000;
    @(negedge clk); @(negedge clk);
    @(negedge clk); prof_pins = 4'b0001;
    @(negedge clk);
    chk("R9 one edge: old", ftw_o, pw(0));
    @(negedge clk);
    chk("R9 two edges: new", ftw_o, pw(8));

    // R2 rewrite of an in-use slot waits for the update
    wr(5'd24, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R2 slot rewrite held", ftw_o, pw(8));
    upd();
    @(negedge clk);
    chk("R2 slot rewrite applied", ftw_o, 32'hDEAD_BEEF);

    // R12 auto-clear with single tone
    wr(5'd0, 32'h0000_0020);
    upd();
    @(negedge clk);
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      chk("R12/R10 phase after auto-clear", 32'(phase_o), 32'(14'(3 * (j - 1) + 100)));
    end

    // R11 clear-and-hold
    wr(5'd0, 32'h0000_0010);
    upd();
    repeat (2) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R11 held phase", 32'(phase_o), 32'(BASE_P));
    end
    // release: accumulate from zero
    wr(5'd0, 32'h0000_0000);
    upd();
    @(negedge clk);
    chk("R11 still zero at release", 32'(phase_o), 32'(BASE_P));
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      chk("R10 accumulation after release", 32'(phase_o), 32'(14'(3 * j + 100)));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule